// File: doc/BRIEF.md
# Privilege-Qualified Event Counter Bank

This block holds between one and four 32-bit event counters. Each counter has its own 32-bit control register. Software reaches all of the registers through one register port. A write is a single-cycle strobe that carries a register kind, a counter index and data. A read is a combinational lookup on a separate kind and index. The port has no back-pressure: a write takes effect at the clock edge in which its strobe is high, and read data is valid in the same cycle as the address. No data stream crosses the block's edge, so every pin is a plain control or status signal.

Each counter picks one event through the event code in its control register. It adds one on every clock in which two things are true: the chosen event pulse is high, and the current privilege mode is one that its control register enables. Two event codes are common to every counter. Any other code picks from one pulse set on even-numbered counters and from a different pulse set on odd-numbered counters. When the top bit of a counter is set and that counter's interrupt enable is on, the block raises a shared interrupt line and sets a flag bit in a cause word. A chain of read-only flags in the control registers lets software find out how many counters exist.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every control register and every count register is zero, apart from the read-only chain flag in R3. `irq_o` and `cause_o` are both zero.
- R2: A control write keeps these fields, which read back unchanged:
  - bit 0: count at exception level
  - bit 1: count in kernel mode
  - bit 2: count in supervisor mode
  - bit 3: count in user mode
  - bit 4: interrupt enable
  - bits 14:5: event code
  - bits 19:16: thread-group id
  - bits 21:20: thread filter mode
  - bits 29:22: thread id

  Bits 15 and 30 always read 0.
- R3: Control bit 31 is read-only. It reads 1 on every counter index below `NUM_CTR-1` and 0 on the last counter that exists.
- R4: A read of an index at or above `NUM_CTR` returns zero. A write to such an index changes no register.
- R5: The privilege modes are decoded from a 2-bit mode field (00 kernel, 01 supervisor, 10 user, 11 none) and two elevation flags. Kernel mode holds when the field is 00 or either flag is set. Exception level holds when either flag is set. Supervisor and user modes hold only when both flags are clear. A counter is qualified when, for any enabled mode bit, that mode is currently in effect.
- R6: Event codes 0 and 1 select `evt_shared[0]` and `evt_shared[1]` on every counter. A code c from 2 to `EVT_NUM-1` selects bit c-2 of `evt_even` on even-numbered counters and bit c-2 of `evt_odd` on odd-numbered counters. Codes of `EVT_NUM` and above never count.
- R7: A counter adds exactly one at each clock edge where its selected event is high and it is qualified. It wraps from 0xFFFFFFFF to 0.
- R8: A count write in the same cycle as a qualified event loads the written value and discards the increment.
- R9: `irq_o` is the OR, over all counters, of (count bit 31 AND control bit 4). `cause_o` carries `irq_o` at bit 26 and zero in every other bit.
- R10: Writing control bits 4:0 to zero stops the counter and masks its interrupt. The count value is kept, and setting the enables again brings back the interrupt.
- R11: Writing a count value with bit 31 clear removes that counter's interrupt contribution from the clock edge of the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 1 | Write target: 0 control, 1 count |
| wr_idx | input | 2 | Counter index to write |
| wr_data | input | 32 | Write data |
| rd_kind | input | 1 | Read target: 0 control, 1 count |
| rd_idx | input | 2 | Counter index to read |
| rd_data | output | 32 | Combinational read data |
| mode_ksu | input | 2 | Privilege mode field |
| mode_exl | input | 1 | Exception-level flag |
| mode_erl | input | 1 | Error-level flag |
| evt_shared | input | 2 | Event pulses for codes 0 and 1 |
| evt_even | input | EVT_NUM-2 | Event pulses for codes 2 and up on even counters |
| evt_odd | input | EVT_NUM-2 | Event pulses for codes 2 and up on odd counters |
| irq_o | output | 1 | Shared counter interrupt |
| cause_o | output | 32 | Cause word with the interrupt flag at bit 26 |

## Verification
The assertions check the following on every cycle:
- the mode decode never reports two of kernel, supervisor and user at once;
- a counter moves by at most one per cycle, and does not move at all while its mode enables are clear;
- a count write always wins over an increment;
- unimplemented indices read as zero;
- the interrupt stays low while no enable is set.

Some behaviours only the bench's scenarios can show. These are the full mode-by-enable truth table, the mapping of each event code to the right pulse on even and odd counters, field readback and the chain flag, wrap-around, and the way the interrupt rises, is masked, returns and is cleared by a count write across several counters.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int REG_W   = 32;
  localparam int MAX_CTR = 4;
  localparam int IDX_W   = $clog2(MAX_CTR);

  // control enable bits
  localparam int EN_EXL = 0;
  localparam int EN_KRN = 1;
  localparam int EN_SUP = 2;
  localparam int EN_USR = 3;
  localparam int EN_IRQ = 4;

  // event code field
  localparam int EVT_LSB = 5;
  localparam int EVT_W   = 10;

  localparam int MORE_BIT  = 31;
  localparam int OVF_BIT   = 31;
  localparam int CAUSE_BIT = 26;

  // bits kept by a control write: 29:16 and 14:0
  localparam logic [REG_W-1:0] CTL_KEEP_MASK = 32'h3FFF_7FFF;

  localparam logic [1:0] KSU_KERNEL = 2'b00;
  localparam logic [1:0] KSU_SUPER  = 2'b01;
  localparam logic [1:0] KSU_USER   = 2'b10;

  typedef enum logic {REG_CTL = 1'b0, REG_CNT = 1'b1} reg_kind_e;

  typedef struct packed {
    logic at_exl;
    logic in_kernel;
    logic in_super;
    logic in_user;
  } mode_t;
endpackage

// File: rtl/pmc_mode_decode.sv
`timescale 1ns/1ps
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ksu,
  input  logic       exl,
  input  logic       erl,
  output mode_t      mode
);
  logic elevated;
  assign elevated       = exl | erl;
  assign mode.at_exl    = elevated;
  assign mode.in_kernel = (ksu == KSU_KERNEL) | elevated;
  assign mode.in_super  = (ksu == KSU_SUPER) & ~elevated;
  assign mode.in_user   = (ksu == KSU_USER) & ~elevated;

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode.in_kernel, mode.in_super, mode.in_user})); // R5
  AST_EXL_IS_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    mode.at_exl |-> mode.in_kernel); // R5
endmodule

// File: rtl/pmc_counter_slice.sv
`timescale 1ns/1ps
module pmc_counter_slice
  import pmc_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int NUM_CTR = 4,
  parameter int EVT_NUM = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl,
  input  logic               wr_cnt,
  input  logic [REG_W-1:0]   wr_data,
  input  mode_t              mode,
  input  logic [1:0]         evt_shared,
  input  logic [EVT_NUM-3:0] evt_set,
  output logic [REG_W-1:0]   ctl_rd,
  output logic [REG_W-1:0]   cnt_rd,
  output logic               irq_req,
  output logic               ie_o
);
  localparam int   SET_W    = EVT_NUM - 2;
  localparam logic HAS_MORE = (IDX < NUM_CTR - 1);

  logic [REG_W-1:0] ctl_q, cnt_q;
  logic [EVT_W-1:0] code;
  logic             mode_ok, evt_hit, bump;

  assign code = ctl_q[EVT_LSB +: EVT_W];

  always_comb begin
    mode_ok = (ctl_q[EN_EXL] & mode.at_exl)
            | (ctl_q[EN_KRN] & mode.in_kernel)
            | (ctl_q[EN_SUP] & mode.in_super)
            | (ctl_q[EN_USR] & mode.in_user);
  end

  always_comb begin
    evt_hit = 1'b0;
    if (code == EVT_W'(0)) evt_hit = evt_shared[0];
    if (code == EVT_W'(1)) evt_hit = evt_shared[1];
    for (int k = 0; k < SET_W; k++) begin
      if (code == EVT_W'(k + 2)) evt_hit = evt_set[k];
    end
  end

  assign bump = mode_ok & evt_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wr_data & CTL_KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (bump)   cnt_q <= cnt_q + 1'b1;
  end

  assign ctl_rd  = ctl_q | (REG_W'(HAS_MORE) << MORE_BIT);
  assign cnt_rd  = cnt_q;
  assign irq_req = cnt_q[OVF_BIT] & ctl_q[EN_IRQ];
  assign ie_o    = ctl_q[EN_IRQ];

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data)); // R8
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 32'd1)); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && ctl_q[EN_USR:EN_EXL] == 4'b0) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/pmc_irq_merge.sv
`timescale 1ns/1ps
module pmc_irq_merge
  import pmc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]     req,
  output logic             irq,
  output logic [REG_W-1:0] cause
);
  assign irq   = |req;
  assign cause = REG_W'(irq) << CAUSE_BIT;
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int EVT_NUM = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_kind,
  input  logic [1:0]         wr_idx,
  input  logic [31:0]        wr_data,
  input  logic               rd_kind,
  input  logic [1:0]         rd_idx,
  output logic [31:0]        rd_data,
  input  logic [1:0]         mode_ksu,
  input  logic               mode_exl,
  input  logic               mode_erl,
  input  logic [1:0]         evt_shared,
  input  logic [EVT_NUM-3:0] evt_even,
  input  logic [EVT_NUM-3:0] evt_odd,
  output logic               irq_o,
  output logic [31:0]        cause_o
);
  localparam int SET_W = EVT_NUM - 2;

  mode_t            mode;
  logic [REG_W-1:0] ctl_rd [NUM_CTR];
  logic [REG_W-1:0] cnt_rd [NUM_CTR];
  logic [NUM_CTR-1:0] irq_req, ie_vec;

  pmc_mode_decode u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .ksu  (mode_ksu),
    .exl  (mode_exl),
    .erl  (mode_erl),
    .mode (mode)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic             wr_ctl_hit, wr_cnt_hit;
    logic [SET_W-1:0] set_sel;

    assign wr_ctl_hit = wr_en && (wr_kind == REG_CTL) && (wr_idx == IDX_W'(g));
    assign wr_cnt_hit = wr_en && (wr_kind == REG_CNT) && (wr_idx == IDX_W'(g));

    if (g % 2 == 0) begin : g_even
      assign set_sel = evt_even;
    end else begin : g_odd
      assign set_sel = evt_odd;
    end

    pmc_counter_slice #(
      .IDX    (g),
      .NUM_CTR(NUM_CTR),
      .EVT_NUM(EVT_NUM)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (wr_ctl_hit),
      .wr_cnt    (wr_cnt_hit),
      .wr_data   (wr_data),
      .mode      (mode),
      .evt_shared(evt_shared),
      .evt_set   (set_sel),
      .ctl_rd    (ctl_rd[g]),
      .cnt_rd    (cnt_rd[g]),
      .irq_req   (irq_req[g]),
      .ie_o      (ie_vec[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_CTR; g++) begin
      if (rd_idx == IDX_W'(g)) rd_data = (rd_kind == REG_CNT) ? cnt_rd[g] : ctl_rd[g];
    end
  end

  pmc_irq_merge #(.N(NUM_CTR)) u_irq (
    .req  (irq_req),
    .irq  (irq_o),
    .cause(cause_o)
  );

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= NUM_CTR) |-> rd_data == 32'd0); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_vec == '0) |-> !irq_o); // R9
endmodule

// File: tb/pmc_bank_test.sv
`timescale 1ns/1ps
module pmc_bank_test;
  localparam int NC = 3;
  localparam int EN = 8;
  localparam int SW = EN - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_kind = 1'b0, rd_kind = 1'b0;
  logic [1:0]    wr_idx = '0, rd_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [1:0]    mode_ksu = '0;
  logic          mode_exl = 1'b0, mode_erl = 1'b0;
  logic [1:0]    evt_shared = '0;
  logic [SW-1:0] evt_even = '0, evt_odd = '0;
  logic          irq_o;
  logic [31:0]   cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmc_bank #(.NUM_CTR(NC), .EVT_NUM(EN)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data),
    .mode_ksu(mode_ksu), .mode_exl(mode_exl), .mode_erl(mode_erl),
    .evt_shared(evt_shared), .evt_even(evt_even), .evt_odd(evt_odd),
    .irq_o(irq_o), .cause_o(cause_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic kind, input int idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_idx = 2'(idx); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic kind, input int idx, output logic [31:0] data);
    rd_kind = kind; rd_idx = 2'(idx);
    #1;
    data = rd_data;
  endtask

  // source s: 0..1 shared, 2..7 even bits, 8..13 odd bits
  task automatic pulse(input int src, input int cycles);
    if (src < 2) evt_shared[src] = 1'b1;
    else if (src < EN) evt_even[src-2] = 1'b1;
    else evt_odd[src-EN] = 1'b1;
    repeat (cycles) @(negedge clk);
    evt_shared = '0; evt_even = '0; evt_odd = '0;
  endtask

  function automatic bit qual(input int m, input int en);
    bit elev, kern, sup, usr;
    elev = m[2] | m[3];
    kern = (m[1:0] == 2'b00) | elev;
    sup  = (m[1:0] == 2'b01) & ~elev;
    usr  = (m[1:0] == 2'b10) & ~elev;
    return (en[0] & elev) | (en[1] & kern) | (en[2] & sup) | (en[3] & usr);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R3 chain flag
    for (int i = 0; i < NC; i++) begin
      rd(1'b1, i, v); check("R1 count reset", v, 32'd0);
      rd(1'b0, i, v); check("R1/R3 control reset", v, (i < NC-1) ? 32'h8000_0000 : 32'd0);
    end
    check("R1 irq reset", {31'd0, irq_o}, 32'd0);
    check("R1 cause reset", cause_o, 32'd0);

    // R2/R3 field readback
    wr(1'b0, 1, 32'hFFFF_FFFF);
    rd(1'b0, 1, v); check("R2 ctl1 all ones", v, 32'hBFFF_7FFF);
    wr(1'b0, 2, 32'hFFFF_FFFF);
    rd(1'b0, 2, v); check("R3 last ctl has no chain flag", v, 32'h3FFF_7FFF);
    wr(1'b0, 1, 32'h0015_A5A5);
    rd(1'b0, 1, v); check("R2 ctl1 pattern", v, 32'h8015_25A5);
    wr(1'b0, 1, 32'd0); wr(1'b0, 2, 32'd0);
    wr(1'b1, 1, 32'd0); wr(1'b1, 2, 32'd0);

    // R5 full mode x enable sweep on counter 0, event code 0
    for (int m = 0; m < 16; m++) begin
      mode_ksu = 2'(m); mode_exl = m[2]; mode_erl = m[3];
      for (int e = 0; e < 16; e++) begin
        wr(1'b0, 0, 32'(e));
        wr(1'b1, 0, 32'd0);
        pulse(0, 3);
        rd(1'b1, 0, v);
        check("R5 mode qualification", v, qual(m, e) ? 32'd3 : 32'd0);
      end
    end
    wr(1'b0, 0, 32'd0);

    // R6/R7 event code sweep, user mode, weighted pulses
    mode_ksu = 2'b10; mode_exl = 1'b0; mode_erl = 1'b0;
    for (int i = 0; i < NC; i++) begin
      for (int c = 0; c < EN + 2; c++) begin
        int exp;
        wr(1'b0, i, 32'h8 | (32'(c) << 5));
        wr(1'b1, i, 32'd0);
        for (int s = 0; s < 2 + 2*SW; s++) pulse(s, s + 1);
        if (c < 2) exp = c + 1;
        else if (c < EN) exp = (i % 2 == 0) ? c + 1 : c + 7;
        else exp = 0;
        rd(1'b1, i, v);
        check("R6 event selection", v, 32'(exp));
      end
      wr(1'b0, i, 32'd0);
      wr(1'b1, i, 32'd0);
    end

    // R8 write beats increment, R7 one per cycle
    wr(1'b0, 0, 32'h8);
    evt_shared[0] = 1'b1;
    wr(1'b1, 0, 32'd100);
    rd(1'b1, 0, v); check("R8 write priority", v, 32'd100);
    @(negedge clk);
    rd(1'b1, 0, v); check("R7 single increment", v, 32'd101);
    evt_shared = '0;

    // R9 overflow via increment
    wr(1'b0, 0, 32'h18);
    wr(1'b1, 0, 32'h7FFF_FFFE);
    pulse(0, 1);
    check("R9 no irq below bit 31", {31'd0, irq_o}, 32'd0);
    pulse(0, 1);
    rd(1'b1, 0, v); check("R9 count at bit 31", v, 32'h8000_0000);
    check("R9 irq raised", {31'd0, irq_o}, 32'd1);
    check("R9 cause bit 26", cause_o, 32'h0400_0000);

    // R10 freeze and mask, value kept
    wr(1'b0, 0, 32'd0);
    check("R10 irq masked", {31'd0, irq_o}, 32'd0);
    pulse(0, 4);
    rd(1'b1, 0, v); check("R10 count frozen", v, 32'h8000_0000);
    wr(1'b0, 0, 32'h18);
    check("R10 irq restored", {31'd0, irq_o}, 32'd1);

    // R11 count write clears contribution
    wr(1'b1, 0, 32'd5);
    check("R11 irq cleared by write", {31'd0, irq_o}, 32'd0);

    // R9 OR across counters
    wr(1'b0, 1, 32'h10); wr(1'b1, 1, 32'h8000_0000);
    wr(1'b0, 2, 32'h10); wr(1'b1, 2, 32'h8000_0001);
    check("R9 two sources", {31'd0, irq_o}, 32'd1);
    wr(1'b1, 1, 32'd0);
    check("R11 other source holds irq", {31'd0, irq_o}, 32'd1);
    wr(1'b1, 2, 32'd0);
    check("R11 all cleared", cause_o, 32'd0);

    // R7 wrap
    wr(1'b1, 0, 32'hFFFF_FFFF);
    check("R9 irq at all ones", {31'd0, irq_o}, 32'd1);
    pulse(0, 1);
    rd(1'b1, 0, v); check("R7 wrap to zero", v, 32'd0);
    check("R7 irq drops on wrap", {31'd0, irq_o}, 32'd0);

    // R4 unimplemented index
    wr(1'b0, 3, 32'hFFFF_FFFF);
    wr(1'b1, 3, 32'h1234_5678);
    rd(1'b0, 3, v); check("R4 ctl read zero", v, 32'd0);
    rd(1'b1, 3, v); check("R4 cnt read zero", v, 32'd0);
    rd(1'b0, 0, v); check("R4 ctl0 untouched", v, 32'h8000_0018);
    rd(1'b0, 1, v); check("R4 ctl1 untouched", v, 32'h8000_0010);
    rd(1'b0, 2, v); check("R4 ctl2 untouched", v, 32'h0000_0010);
    for (int i = 0; i < NC; i++) begin
      rd(1'b1, i, v); check("R4 counts untouched", v, 32'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule